// File: doc/BRIEF.md
# Two-Port Semaphore Flag Unit

This block holds eight hardware token flags that two independent ports use to coordinate access to a shared resource. Each port has a set of active-low controls: flag select, chip select, write select, read enable and two byte selects. It also has a 3-bit flag index, a 16-bit write bus and a 16-bit read bus. Software claims a flag by writing 0 to it and gives it back by writing 1. A write looks only at data bit 0. After a claim, software reads the flag back to learn whether the claim succeeded.

Each flag grants ownership to at most one port at a time. A claim that is refused stays latched and is granted automatically when the holder gives the flag back. When both ports claim the same free flag in one cycle, the left port wins. The read bus repeats the flag value on every bit: 0 means the reading port owns the flag, and 1 means it does not. The unit is clocked, and state changes on the rising edge. Reads are combinational from the registered flag state.

Top module: `sem_flag_unit`

## Requirements
- R1: There are eight flags, and the port's index input (`*_idx`, 3 bits) selects one of them. Each flag is independent of the others.
- R2: A write uses only write-bus bit 0. Bits 15..1 have no effect on any flag.
- R3: While a read is active, `*_rd_act` is 1 and all 16 bits of `*_rdata` carry the same flag value. When no read is active, `*_rd_act` is 0 and `*_rdata` is 0.
- R4: An access needs `*_sel_n` low and `*_cs_n` high. If `*_sel_n` and `*_cs_n` are both low, the access is ignored and no flag changes. A read also needs `*_wr_n` high and `*_rd_n` low.
- R5: A write needs at least one byte select (`*_ub_n`, `*_lb_n`) low. With both high the write has no effect. Reads do not depend on the byte selects.
- R6: Writing 0 to a free flag grants it to the writer from the next cycle. The owner then reads 0 (0x0000), and the other port reads 1 (0xFFFF).
- R7: The owner writing 1 frees the flag. A non-owner writing 1 leaves ownership unchanged and withdraws its own pending claim.
- R8: A port that writes 0 to a flag owned by the other port keeps a pending claim. That claim becomes ownership in the cycle after the owner releases the flag.
- R9: If both ports write 0 to the same free flag in the same cycle, the left port is granted and the right port's claim stays pending.
- R10: The asynchronous active-low reset `rst_n` is released through a two-stage synchronizer. While reset is held, all flags are free and all pending claims are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sel_n | input | 1 | Left flag select, active low |
| l_cs_n | input | 1 | Left chip select, must be high for a flag access |
| l_wr_n | input | 1 | Left write select: 0 write, 1 read |
| l_rd_n | input | 1 | Left read enable, active low |
| l_ub_n | input | 1 | Left upper byte select, active low |
| l_lb_n | input | 1 | Left lower byte select, active low |
| l_idx | input | 3 | Left flag index |
| l_wdata | input | 16 | Left write bus, only bit 0 used |
| l_rdata | output | 16 | Left read bus |
| l_rd_act | output | 1 | Left read active |
| r_sel_n | input | 1 | Right flag select, active low |
| r_cs_n | input | 1 | Right chip select, must be high for a flag access |
| r_wr_n | input | 1 | Right write select: 0 write, 1 read |
| r_rd_n | input | 1 | Right read enable, active low |
| r_ub_n | input | 1 | Right upper byte select, active low |
| r_lb_n | input | 1 | Right lower byte select, active low |
| r_idx | input | 3 | Right flag index |
| r_wdata | input | 16 | Right write bus, only bit 0 used |
| r_rdata | output | 16 | Right read bus |
| r_rd_act | output | 1 | Right read active |

## Verification
The assertions assume that both ports' controls are known values that are synchronous to `clk` and hold steady around the rising edge. They also assume that a claim and a release from the same port never reach the same flag in the same cycle, which the single write bit of each port already guarantees. The stimulus changes every input only on the falling edge. It sweeps the flag reads between edges, so no read overlaps a write decision. The pseudo-random control patterns deliberately include the ignored select/chip-select combination and the case where both byte selects are high.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_FREE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } own_t;
endpackage

// File: rtl/sem_rst_sync.sv
module sem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              sel_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic [DATA_W-1:0] wdata,
  output logic              wr_go,
  output logic              rd_go,
  output logic              wr_bit,
  output logic [IDX_W-1:0]  idx
);
  logic flag_cycle;
  logic byte_any;

  always_comb begin
    flag_cycle = !sel_n && cs_n;
    byte_any   = !ub_n || !lb_n;
    wr_go      = flag_cycle && !wr_n && byte_any;
    rd_go      = flag_cycle && wr_n && !rd_n;
    wr_bit     = wdata[0];
    idx        = idx_in;
  end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic l_claim,
  input  logic l_free,
  input  logic r_claim,
  input  logic r_free,
  output own_t owner
);
  own_t own_q, own_d;
  logic req_l_q, req_l_d;
  logic req_r_q, req_r_d;
  logic upd_en;

  always_comb begin
    upd_en  = l_claim || l_free || r_claim || r_free;
    req_l_d = req_l_q;
    req_r_d = req_r_q;
    if (l_claim) req_l_d = 1'b1;
    if (l_free)  req_l_d = 1'b0;
    if (r_claim) req_r_d = 1'b1;
    if (r_free)  req_r_d = 1'b0;
    own_d = own_q;
    if (own_q == OWN_LEFT  && !req_l_d) own_d = OWN_FREE;
    if (own_q == OWN_RIGHT && !req_r_d) own_d = OWN_FREE;
    if (own_d == OWN_FREE) begin
      if (req_l_d)      own_d = OWN_LEFT;
      else if (req_r_d) own_d = OWN_RIGHT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q   <= OWN_FREE;
      req_l_q <= 1'b0;
      req_r_q <= 1'b0;
    end else if (upd_en) begin
      own_q   <= own_d;
      req_l_q <= req_l_d;
      req_r_q <= req_r_d;
    end
  end

  assign owner = own_q;

  // R7: only the holder's own release takes a flag from the left port
  p_hold_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_LEFT && !l_free) |=> (own_q == OWN_LEFT));
  p_hold_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_RIGHT && !r_free) |=> (own_q == OWN_RIGHT));
  // R9: same-cycle claims on a free flag favour the left port
  p_tie_left_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_FREE && l_claim && r_claim) |=> (own_q == OWN_LEFT));
  // R8: a pending right claim takes over on left release
  p_handoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_LEFT && l_free && req_r_q && !r_free) |=> (own_q == OWN_RIGHT));
endmodule

// File: rtl/sem_flag_unit.sv
module sem_flag_unit
  import sem_pkg::*;
#(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 16,
  localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel_n,
  input  logic              l_cs_n,
  input  logic              l_wr_n,
  input  logic              l_rd_n,
  input  logic              l_ub_n,
  input  logic              l_lb_n,
  input  logic [IDX_W-1:0]  l_idx,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rd_act,
  input  logic              r_sel_n,
  input  logic              r_cs_n,
  input  logic              r_wr_n,
  input  logic              r_rd_n,
  input  logic              r_ub_n,
  input  logic              r_lb_n,
  input  logic [IDX_W-1:0]  r_idx,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rd_act
);
  logic rst_n_int;
  logic l_wr, l_rd, l_bit;
  logic r_wr, r_rd, r_bit;
  logic [IDX_W-1:0] l_sel_idx, r_sel_idx;
  own_t owner [NUM_FLAGS];
  logic [2*NUM_FLAGS-1:0] own_vec;
  logic l_val, r_val;

  sem_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  sem_port_dec #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_dec_l (
    .sel_n(l_sel_n), .cs_n(l_cs_n), .wr_n(l_wr_n), .rd_n(l_rd_n),
    .ub_n(l_ub_n), .lb_n(l_lb_n), .idx_in(l_idx), .wdata(l_wdata),
    .wr_go(l_wr), .rd_go(l_rd), .wr_bit(l_bit), .idx(l_sel_idx)
  );

  sem_port_dec #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_dec_r (
    .sel_n(r_sel_n), .cs_n(r_cs_n), .wr_n(r_wr_n), .rd_n(r_rd_n),
    .ub_n(r_ub_n), .lb_n(r_lb_n), .idx_in(r_idx), .wdata(r_wdata),
    .wr_go(r_wr), .rd_go(r_rd), .wr_bit(r_bit), .idx(r_sel_idx)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    logic hit_l, hit_r;
    assign hit_l = l_wr && (l_sel_idx == IDX_W'(g));
    assign hit_r = r_wr && (r_sel_idx == IDX_W'(g));
    sem_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n_int),
      .l_claim(hit_l && !l_bit), .l_free(hit_l && l_bit),
      .r_claim(hit_r && !r_bit), .r_free(hit_r && r_bit),
      .owner(owner[g])
    );
    assign own_vec[2*g +: 2] = owner[g];
  end

  always_comb begin
    l_val    = (owner[l_sel_idx] != OWN_LEFT);
    r_val    = (owner[r_sel_idx] != OWN_RIGHT);
    l_rd_act = l_rd;
    r_rd_act = r_rd;
    l_rdata  = l_rd ? {DATA_W{l_val}} : '0;
    r_rdata  = r_rd ? {DATA_W{r_val}} : '0;
  end

  // R4: an ignored left access with the right port idle changes nothing
  p_illegal_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!l_sel_n && !l_cs_n && r_sel_n) |=> $stable(own_vec));
  // R3: an active read replicates one value across the bus
  p_read_fill_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    l_rd_act |-> ($countones(l_rdata) == 0 || $countones(l_rdata) == DATA_W));
  p_noread_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    !r_rd_act |-> (r_rdata == '0));
endmodule

// File: tb/sem_flag_unit_bench.sv
module sem_flag_unit_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic l_sel_n, l_cs_n, l_wr_n, l_rd_n, l_ub_n, l_lb_n;
  logic [2:0] l_idx;
  logic [15:0] l_wdata, l_rdata;
  logic l_rd_act;
  logic r_sel_n, r_cs_n, r_wr_n, r_rd_n, r_ub_n, r_lb_n;
  logic [2:0] r_idx;
  logic [15:0] r_wdata, r_rdata;
  logic r_rd_act;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int own_m [8];
  bit pl_m [8];
  bit pr_m [8];
  logic [31:0] lfsr = 32'h1ACE_2B3D;

  always #10 clk = ~clk;

  sem_flag_unit u_sem_flag_unit (
    .clk(clk), .rst_n(rst_n),
    .l_sel_n(l_sel_n), .l_cs_n(l_cs_n), .l_wr_n(l_wr_n), .l_rd_n(l_rd_n),
    .l_ub_n(l_ub_n), .l_lb_n(l_lb_n), .l_idx(l_idx), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_rd_act(l_rd_act),
    .r_sel_n(r_sel_n), .r_cs_n(r_cs_n), .r_wr_n(r_wr_n), .r_rd_n(r_rd_n),
    .r_ub_n(r_ub_n), .r_lb_n(r_lb_n), .r_idx(r_idx), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_rd_act(r_rd_act)
  );

  task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    l_sel_n = 1; l_cs_n = 1; l_wr_n = 1; l_rd_n = 1; l_ub_n = 1; l_lb_n = 1;
    l_idx = 0; l_wdata = 0;
    r_sel_n = 1; r_cs_n = 1; r_wr_n = 1; r_rd_n = 1; r_ub_n = 1; r_lb_n = 1;
    r_idx = 0; r_wdata = 0;
  endtask

  task automatic model_clear();
    for (int i = 0; i < 8; i++) begin own_m[i] = 0; pl_m[i] = 0; pr_m[i] = 0; end
  endtask

  // Spec model: claims/releases latch, then ownership resolves with left priority.
  task automatic model_step();
    bit lw, rw;
    lw = !l_sel_n && l_cs_n && !l_wr_n && (!l_ub_n || !l_lb_n);
    rw = !r_sel_n && r_cs_n && !r_wr_n && (!r_ub_n || !r_lb_n);
    if (lw) pl_m[l_idx] = !l_wdata[0];
    if (rw) pr_m[r_idx] = !r_wdata[0];
    for (int i = 0; i < 8; i++) begin
      if (own_m[i] == 1 && !pl_m[i]) own_m[i] = 0;
      if (own_m[i] == 2 && !pr_m[i]) own_m[i] = 0;
      if (own_m[i] == 0) begin
        if (pl_m[i]) own_m[i] = 1;
        else if (pr_m[i]) own_m[i] = 2;
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    idle_all();
  endtask

  task automatic check_all(input string req);
    for (int f = 0; f < 8; f++) begin
      l_sel_n = 0; l_cs_n = 1; l_wr_n = 1; l_rd_n = 0; l_idx = 3'(f);
      r_sel_n = 0; r_cs_n = 1; r_wr_n = 1; r_rd_n = 0; r_idx = 3'(f);
      #1;
      chk(req, {l_rd_act, l_rdata}, {1'b1, (own_m[f] == 1) ? 16'h0000 : 16'hFFFF});
      chk(req, {r_rd_act, r_rdata}, {1'b1, (own_m[f] == 2) ? 16'h0000 : 16'hFFFF});
    end
    idle_all();
  endtask

  task automatic wr_l(input logic [2:0] f, input logic [15:0] d, input logic ub, input logic lb);
    l_sel_n = 0; l_cs_n = 1; l_wr_n = 0; l_ub_n = ub; l_lb_n = lb; l_idx = f; l_wdata = d;
  endtask

  task automatic wr_r(input logic [2:0] f, input logic [15:0] d, input logic ub, input logic lb);
    r_sel_n = 0; r_cs_n = 1; r_wr_n = 0; r_ub_n = ub; r_lb_n = lb; r_idx = f; r_wdata = d;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_all();
    model_clear();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R10: all flags free after reset, R1 each index read
    check_all("R10");
    // R3: no read -> quiet bus
    #1 chk("R3", {l_rd_act, l_rdata}, 17'h0);
    // R4: read enable high gives no read
    l_sel_n = 0; l_cs_n = 1; l_wr_n = 1; l_rd_n = 1; #1;
    chk("R4", {l_rd_act, l_rdata}, 17'h0);
    idle_all();
    // R6/R2: left claims flag 2 with junk in upper bits
    wr_l(3'd2, 16'hFFFE, 1'b0, 1'b1); tick(); check_all("R6");
    chk("R2", 17'(own_m[2]), 17'd1);
    // R8: right claims held flag 2 -> pending
    wr_r(3'd2, 16'h8000, 1'b1, 1'b0); tick(); check_all("R8");
    // R5: write with both byte selects high has no effect
    wr_l(3'd5, 16'h0000, 1'b1, 1'b1); tick(); check_all("R5");
    // R4: select and chip select both low -> ignored
    wr_l(3'd6, 16'h0000, 1'b0, 1'b0); l_cs_n = 0; tick(); check_all("R4");
    // R7: non-owner release withdraws pending, owner keeps flag
    wr_r(3'd2, 16'h0001, 1'b0, 1'b0); tick(); check_all("R7");
    // R7: owner release frees flag 2
    wr_l(3'd2, 16'h0001, 1'b0, 1'b0); tick(); check_all("R7");
    chk("R7", 17'(own_m[2]), 17'd0);
    // R8: handoff on release
    wr_l(3'd3, 16'h0000, 1'b0, 1'b0); tick();
    wr_r(3'd3, 16'h0000, 1'b0, 1'b0); tick();
    wr_l(3'd3, 16'h0001, 1'b0, 1'b0); tick(); check_all("R8");
    chk("R8", 17'(own_m[3]), 17'd2);
    // R9: tie on a free flag
    wr_l(3'd4, 16'h0000, 1'b0, 1'b0); wr_r(3'd4, 16'h0000, 1'b0, 1'b0); tick();
    check_all("R9");
    chk("R9", 17'(own_m[4]), 17'd1);
    wr_l(3'd4, 16'h0001, 1'b0, 1'b0); tick(); check_all("R9");
    // R1: pseudo-random sweep over all flags and control mixes
    for (int it = 0; it < 600; it++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      l_sel_n = lfsr[0] & lfsr[1] & lfsr[2]; l_cs_n = lfsr[3] | lfsr[4];
      l_wr_n = lfsr[5] & lfsr[6]; l_rd_n = lfsr[7];
      l_ub_n = lfsr[8]; l_lb_n = lfsr[9] & lfsr[10];
      l_idx = {lfsr[11] & lfsr[12], lfsr[13], lfsr[14]};
      l_wdata = {lfsr[30:16], lfsr[15]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      r_sel_n = lfsr[0] & lfsr[1] & lfsr[2]; r_cs_n = lfsr[3] | lfsr[4];
      r_wr_n = lfsr[5] & lfsr[6]; r_rd_n = lfsr[7];
      r_ub_n = lfsr[8] & lfsr[9]; r_lb_n = lfsr[10];
      r_idx = {lfsr[11] & lfsr[12], lfsr[13], lfsr[14]};
      r_wdata = {lfsr[16:2], lfsr[15]};
      tick();
      check_all("R1");
    end
    // R10: reset in the middle of activity clears everything
    wr_l(3'd0, 16'h0000, 1'b0, 1'b0); wr_r(3'd1, 16'h0000, 1'b0, 1'b0); tick();
    rst_n = 0; #1;
    model_clear();
    check_all("R10");
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    check_all("R10");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule